// File: doc/BRIEF.md
# DRAM Self-Test Sequencer

This block runs a complete write-then-verify test of a DRAM core without any tester help beyond the memory's own control strobes. It watches the row strobe, column strobe, write enable and address pins. It enters test mode when the column strobe falls ahead of the row strobe while write enable is low and a key value sits on the address pins.

Once armed, every further column-before-row cycle moves the test forward by one word. The word address comes from a row counter that carries into a column counter, so the row changes fastest. The first sweep writes a checkerboard into every 16-bit word. The second sweep reads each word back and compares it with the pattern it should hold. A sticky fail flag records any mismatch, and a done flag marks the end of the last compare.

The array is reached through a plain synchronous word port: a read issued on one clock edge returns its data on the next edge. A row-strobe cycle with the column strobe high, or reset, leaves test mode and clears all test state.

Top module: `dram_bist_seq`

## Requirements
- R1: A falling row strobe with the column strobe already low, write enable low and the address pins equal to parameter KEY sets test_active. The entry cycle itself makes no memory access.
- R2: Outside test mode, the following do not set test_active and make no memory access: a column-before-row cycle with a wrong key, one with write enable high, or a row-strobe-only cycle.
- R3: In the write or read phase, each column-before-row cycle makes exactly one memory access, so mem_en is high for one clock.
- R4: mem_addr is {column, row}. The row counter is ROW_W bits and the column counter is COL_W bits. Both start at zero on entry, and the column counter advances only when the row counter wraps from all ones to zero. Successive accesses therefore go to word addresses 0, 1, 2, … in order.
- R5: The first 2^(ROW_W+COL_W) steps are writes (mem_we high). Bit i of the written word is i[0] XOR row[0] XOR column[0]. With 16 data bits this is 16'hAAAA when row[0] equals column[0], and 16'h5555 otherwise.
- R6: The next 2^(ROW_W+COL_W) steps are reads (mem_we low) over the same address order.
- R7: test_fail goes high after a read returns any bit that differs from its expected checkerboard value. It stays high until test mode is left or reset.
- R8: test_done goes high only after the final read has been compared. Column-before-row cycles after that point make no memory access.
- R9: A falling row strobe with the column strobe high, while in test mode, clears test_active, test_done and test_fail. A later entry starts again from word address 0 in the write phase.
- R10: Synchronous active-high reset clears test_active, test_done, test_fail and mem_en.
- R11: When every word reads back as it was written, test_fail stays low through the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | KEY_W | Address pins, carry the entry key |
| mem_en | output | 1 | Word port access strobe |
| mem_we | output | 1 | Word port write select |
| mem_addr | output | ROW_W+COL_W | Word address {column, row} |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one clock after a read |
| test_active | output | 1 | Test mode is armed |
| test_done | output | 1 | Last compare finished |
| test_fail | output | 1 | Sticky mismatch flag |

## Verification
The assertions rely on the strobes being held for at least one clock on each level. That way two row-strobe falls can never land on adjacent clocks, and each access finishes before the next step begins. They also rely on the read data appearing exactly one clock after the read strobe. The bench keeps each strobe level for several clocks and gives its array model a one-clock registered read, so both conditions always hold.

// File: rtl/dram_bist_pkg.sv
package dram_bist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_DONE  = 2'd3
  } bist_state_t;
endpackage

// File: rtl/bist_strobe_decode.sv
module bist_strobe_decode #(
  parameter int KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [KEY_W-1:0] addr,
  output logic             cbr_ev,
  output logic             ras_only_ev,
  output logic             key_ok
);
  logic ras_s, ras_d, cas_s, we_s;
  logic [KEY_W-1:0] addr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_s  <= 1'b1;
      ras_d  <= 1'b1;
      cas_s  <= 1'b1;
      we_s   <= 1'b1;
      addr_s <= '0;
    end else begin
      ras_s  <= ras_n;
      ras_d  <= ras_s;
      cas_s  <= cas_n;
      we_s   <= we_n;
      addr_s <= addr;
    end
  end

  logic ras_fall;
  assign ras_fall    = ras_d & ~ras_s;
  assign cbr_ev      = ras_fall & ~cas_s;
  assign ras_only_ev = ras_fall & cas_s;
  assign key_ok      = ~we_s & (addr_s == KEY);
endmodule

// File: rtl/bist_addr_scan.sv
module bist_addr_scan #(
  parameter int ROW_W = 10,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             last
);
  localparam logic [ROW_W-1:0] ROW_MAX = {ROW_W{1'b1}};
  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};

  logic row_wrap;
  assign row_wrap = (row == ROW_MAX);
  assign last     = row_wrap & (col == COL_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      row <= '0;
      col <= '0;
    end else if (inc) begin
      row <= row + 1'b1;
      if (row_wrap) col <= col + 1'b1;
    end
  end

  // R4
  row_first_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && row != ROW_MAX) |=> $stable(col));
endmodule

// File: rtl/bist_compare.sv
module bist_compare #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              issue,
  input  logic              issue_last,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic              done
);
  logic pend_a, pend_b, last_a, last_b;
  logic [DATA_W-1:0] exp_a, exp_b;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      last_a <= 1'b0;
      last_b <= 1'b0;
      exp_a  <= '0;
      exp_b  <= '0;
      fail   <= 1'b0;
      done   <= 1'b0;
    end else begin
      pend_a <= issue;
      last_a <= issue & issue_last;
      if (issue) exp_a <= exp_word;
      pend_b <= pend_a;
      last_b <= last_a;
      exp_b  <= exp_a;
      if (pend_b && (rdata != exp_b)) fail <= 1'b1;
      if (pend_b && last_b) done <= 1'b1;
    end
  end

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> fail);
endmodule

// File: rtl/dram_bist_seq.sv
module dram_bist_seq
  import dram_bist_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY = 8'hA5,
  localparam int AW = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [KEY_W-1:0]  addr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              test_active,
  output logic              test_done,
  output logic              test_fail
);
  bist_state_t state;
  logic cbr_ev, ras_only_ev, key_ok;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic last, enter, scan_inc, leave, rd_issue;
  logic [DATA_W-1:0] pat;

  bist_strobe_decode #(.KEY_W(KEY_W), .KEY(KEY)) u_dec (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .cbr_ev(cbr_ev), .ras_only_ev(ras_only_ev), .key_ok(key_ok)
  );

  assign enter    = cbr_ev & key_ok & (state == ST_IDLE);
  assign leave    = ras_only_ev;
  assign scan_inc = cbr_ev & ((state == ST_WRITE) | (state == ST_READ));
  assign rd_issue = cbr_ev & (state == ST_READ);

  bist_addr_scan #(.ROW_W(ROW_W), .COL_W(COL_W)) u_scan (
    .clk(clk), .rst(rst), .clr(enter | leave), .inc(scan_inc),
    .row(row), .col(col), .last(last)
  );

  // checkerboard: cell parity xor row and column parity
  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      pat[i] = (i % 2 == 1) ^ row[0] ^ col[0];
  end

  bist_compare #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clr(enter | leave), .issue(rd_issue),
    .issue_last(last), .exp_word(pat), .rdata(mem_rdata),
    .fail(test_fail), .done(test_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_en <= 1'b0;
      mem_we <= 1'b0;
      if (leave) begin
        state <= ST_IDLE;
      end else if (cbr_ev) begin
        case (state)
          ST_IDLE:  if (key_ok) state <= ST_WRITE;
          ST_WRITE: begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {col, row};
            mem_wdata <= pat;
            if (last) state <= ST_READ;
          end
          ST_READ: begin
            mem_en   <= 1'b1;
            mem_addr <= {col, row};
            if (last) state <= ST_DONE;
          end
          default: state <= ST_DONE;
        endcase
      end
    end
  end

  assign test_active = (state != ST_IDLE);

  // R3
  single_access_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> !mem_en);
  // R8
  done_active_chk: assert property (@(posedge clk) disable iff (rst)
    test_done |-> test_active);
  // R9
  entry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    enter |=> (row == '0 && col == '0));
  // R8
  no_access_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && $past(state) == ST_DONE) |-> !mem_en);
endmodule

// File: tb/sim_dram_bist_seq.sv
module sim_dram_bist_seq;
  localparam int RW = 3, CW = 2, DW = 16, KW = 8;
  localparam int NW = 1 << (RW + CW);
  localparam logic [KW-1:0] KEYV = 8'hA5;

  logic clk = 1'b0, rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [KW-1:0] addr = '0;
  logic mem_en, mem_we, test_active, test_done, test_fail;
  logic [RW+CW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  dram_bist_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .KEY_W(KW), .KEY(KEYV)) u0 (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .test_active(test_active), .test_done(test_done),
    .test_fail(test_fail)
  );

  logic [DW-1:0] mem [NW];
  logic corrupt = 1'b0;
  int acc_cnt = 0, base = 0, mon_checks = 0, mon_errs = 0;
  int checks = 0, errs = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] cb(int a);
    int r, c;
    r = a % (1 << RW);
    c = a / (1 << RW);
    return ((r % 2) == (c % 2)) ? 16'hAAAA : 16'h5555;
  endfunction

  // array model with one-clock registered read; word 5 can be corrupted on read
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr] ^ ((corrupt && mem_addr == 5) ? 16'h0008 : 16'h0000);
    end
  end

  // access monitor: order, direction and data of every access
  always @(posedge clk) begin
    if (!rst && mem_en) begin
      int k, ea;
      k = acc_cnt - base;
      ea = k % NW;
      mon_checks++;
      if (mem_addr != ea[RW+CW-1:0] || mem_we != (k < NW) || k >= 2 * NW) begin
        mon_errs++;
        $display("FAIL R4/R6 access %0d: addr=%0d we=%0d expected addr=%0d we=%0d",
                 k, mem_addr, mem_we, ea, (k < NW));
      end
      if (mem_we && mem_wdata != cb(ea)) begin
        mon_errs++;
        $display("FAIL R5 data at %0d: got %h expected %h", ea, mem_wdata, cb(ea));
      end
      acc_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cbr(input logic wel, input logic [KW-1:0] a);
    @(negedge clk); we_n = wel; addr = a; cas_n = 1'b0;
    repeat (2) @(negedge clk); ras_n = 1'b0;
    repeat (3) @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; addr = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ras_only();
    @(negedge clk); ras_n = 1'b0;
    repeat (3) @(negedge clk); ras_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic enter();
    cbr(1'b0, KEYV);
    base = acc_cnt;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 active", test_active, 0);
    chk("R10 done", test_done, 0);
    chk("R10 fail", test_fail, 0);
    chk("R10 mem_en", mem_en, 0);

    // R2 no entry on wrong key, WE high, or RAS-only
    cbr(1'b0, 8'h5A);
    chk("R2 wrong key", test_active, 0);
    cbr(1'b1, KEYV);
    chk("R2 we high", test_active, 0);
    ras_only();
    chk("R2 ras only", test_active, 0);
    chk("R2 no access", acc_cnt, 0);

    // R1 entry
    enter();
    chk("R1 active", test_active, 1);
    chk("R1 no access on entry", acc_cnt, 0);

    // R3 R4 R5 write phase
    for (int i = 0; i < NW; i++) cbr(1'b1, '0);
    chk("R3 write accesses", acc_cnt - base, NW);
    chk("R8 not done after writes", test_done, 0);

    // R6 read phase, R8 done timing, R11 clean
    for (int i = 0; i < NW - 1; i++) cbr(1'b1, '0);
    chk("R8 done before last", test_done, 0);
    cbr(1'b1, '0);
    chk("R6 read accesses", acc_cnt - base, 2 * NW);
    chk("R8 done", test_done, 1);
    chk("R11 no fail", test_fail, 0);
    cbr(1'b1, '0);
    chk("R8 no access after done", acc_cnt - base, 2 * NW);

    // R9 exit clears
    ras_only();
    chk("R9 active cleared", test_active, 0);
    chk("R9 done cleared", test_done, 0);

    // R7 injected mismatch on word 5
    enter();
    for (int i = 0; i < NW; i++) cbr(1'b1, '0);
    corrupt = 1'b1;
    for (int i = 0; i < 5; i++) cbr(1'b1, '0);
    chk("R7 no fail before bad word", test_fail, 0);
    cbr(1'b1, '0);
    chk("R7 fail on bad word", test_fail, 1);
    for (int i = 6; i < NW; i++) cbr(1'b1, '0);
    chk("R7 fail sticky", test_fail, 1);
    chk("R8 done with fail", test_done, 1);
    corrupt = 1'b0;
    ras_only();
    chk("R9 fail cleared", test_fail, 0);

    // R9 partial run, exit, restart from word 0 (monitor checks order)
    enter();
    for (int i = 0; i < 7; i++) cbr(1'b1, '0);
    ras_only();
    enter();
    for (int i = 0; i < 3; i++) cbr(1'b1, '0);
    chk("R9 restart accesses", acc_cnt - base, 3);

    // R10 reset mid-test
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R10 active after reset", test_active, 0);
    chk("R10 mem_en after reset", mem_en, 0);

    finish_run();
  end
endmodule